// File: doc/BRIEF.md
# Ring Node Command Forwarder

This block is one station on a one-way ring of processing nodes. Bytes come in from the upstream neighbour and are grouped into packets. Each packet starts with a kind byte. An instruction packet is passed on to the downstream neighbour before the node acts on it. After forwarding, the node gives its local processing logic a single-cycle execute strobe that carries the opcode.

One opcode, the route operation, makes the node insert a data packet into the ring after it executes. That packet holds a kind header, an address byte and a data byte, and both payload bytes are taken from input ports. When a node receives a data packet, it consumes the packet and runs a no-operation. A special terminator byte shuts down the whole ring: each node passes it on once and then goes permanently silent.

The downstream side uses a start strobe plus a busy flag from the transmitter, and it is gated by the neighbour's ready signal. If that ready signal drops partway through a multi-byte packet, the node flags an error and sends the whole packet again, starting from its header.

Top module: `ring_node`

## Requirements
- R1: After reset, `up_ready` is 1 and `tx_start`, `exec_valid` and `err` are 0.
- R2: Kind byte 0x01 introduces one instruction byte. Kind byte 0x02 introduces a data packet made of an address byte followed by a data byte.
- R3: A kind byte other than 0x01, 0x02 or the terminator raises `err` for one cycle. Nothing is sent downstream and no execute strobe occurs. `up_ready` stays 1.
- R4: When an instruction byte is received, `up_ready` falls on the next cycle. The node sends 0x01 and then the instruction byte downstream, and both bytes have been issued before the execute strobe.
- R5: A downstream byte is issued only in a cycle after one in which `dn_ready` was 1 and `tx_busy` was 0. Consecutive starts are separated by at least one idle cycle. While `dn_ready` is low before the first byte of a packet, the node waits and raises no error.
- R6: If `dn_ready` is 0 when a later byte of a packet is due, `err` pulses once and the packet is sent again from its first byte.
- R7: After forwarding completes, `exec_valid` is high for exactly one cycle and `exec_op` carries the instruction byte.
- R8: When the instruction equals the route opcode (default 0x04), the node then sends 0x02, `route_addr` and `route_data`, with both values sampled in the execute cycle. `up_ready` returns to 1 only after the last of these bytes has been issued. For any other opcode, `up_ready` returns to 1 right after the execute cycle.
- R9: A received data packet is not forwarded. It yields one execute strobe with `exec_op` equal to 0x00, and the node then becomes ready again.
- R10: When the terminator byte (default 0xFF) is received as a kind byte, the node sends it downstream once and then halts. `up_ready` stays 0 and later input is ignored until reset.
- R11: Each `err` pulse lasts one cycle. An unreachable state code returns the node to idle and raises `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Upstream byte strobe |
| rx_byte | input | 8 | Upstream byte |
| up_ready | output | 1 | Node can accept upstream bytes |
| tx_start | output | 1 | Downstream send strobe |
| tx_byte | output | 8 | Downstream byte, valid with `tx_start` |
| tx_busy | input | 1 | Downstream transmitter is busy |
| dn_ready | input | 1 | Downstream neighbour is ready |
| route_addr | input | 8 | Address byte for route data packets |
| route_data | input | 8 | Data byte for route data packets |
| exec_valid | output | 1 | Single-cycle execute strobe |
| exec_op | output | 8 | Opcode carried with the execute strobe |
| err | output | 1 | Single-cycle error pulse |

## Verification
Some properties are checked on every cycle by assertions. These are the send gating on readiness and busy, the idle cycle between starts, the single-cycle width of the execute and error pulses, and the rule that `up_ready` is low during transmission and execution.

Other behaviour can only be shown by the bench scenarios. These cover the byte content and order of the forwarded and inserted packets, the restart after a mid-packet readiness loss, the consumption of data packets without forwarding, rejection of a bad kind byte, and the permanent silence after the terminator.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int BYTE_W    = 8;
    localparam int BURST_MAX = 4;
    localparam int IDX_W     = $clog2(BURST_MAX);

    typedef logic [BYTE_W-1:0] rn_byte_t;

    // Protocol codes that neighbours decode
    localparam rn_byte_t KIND_OP   = 8'h01;
    localparam rn_byte_t KIND_NEWS = 8'h02;
    localparam rn_byte_t OP_NOP    = 8'h00;

    // A short packet queued for downstream transmission
    typedef struct packed {
        logic [IDX_W:0]                 len;
        rn_byte_t [BURST_MAX-1:0]       bytes;
    } rn_burst_t;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_GET_OP   = 4'd1,
        S_GET_ADDR = 4'd2,
        S_GET_DATA = 4'd3,
        S_FORWARD  = 4'd4,
        S_EXEC     = 4'd5,
        S_ROUTE    = 4'd6,
        S_NOP_EXEC = 4'd7,
        S_DYING    = 4'd8,
        S_HALT     = 4'd9
    } rn_state_t;

    function automatic rn_burst_t make_burst(
        input logic [IDX_W:0] n,
        input rn_byte_t       b0,
        input rn_byte_t       b1,
        input rn_byte_t       b2
    );
        rn_burst_t r;
        r.len      = n;
        r.bytes    = '0;
        r.bytes[0] = b0;
        r.bytes[1] = b1;
        r.bytes[2] = b2;
        return r;
    endfunction

endpackage

// File: rtl/rn_tx_seq.sv
module rn_tx_seq
    import rn_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  rn_burst_t burst,
    input  logic      dn_ready,
    input  logic      tx_busy,
    output logic      tx_start,
    output rn_byte_t  tx_byte,
    output logic      done,
    output logic      drop
);

    rn_burst_t        cur;
    logic             active;
    logic             gap;
    logic [IDX_W-1:0] idx;
    logic             last_byte;

    assign last_byte = ({1'b0, idx} == (cur.len - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            active   <= 1'b0;
            gap      <= 1'b0;
            idx      <= '0;
            tx_start <= 1'b0;
            tx_byte  <= '0;
            done     <= 1'b0;
            drop     <= 1'b0;
        end else begin
            tx_start <= 1'b0;
            done     <= 1'b0;
            drop     <= 1'b0;
            if (load) begin
                cur    <= burst;
                active <= 1'b1;
                idx    <= '0;
                gap    <= 1'b0;
            end else if (active) begin
                if (gap) begin
                    // let the transmitter raise busy before the next look
                    gap <= 1'b0;
                end else if (idx != '0 && !dn_ready) begin
                    // neighbour went away mid-packet: start over from header
                    idx  <= '0;
                    drop <= 1'b1;
                end else if (dn_ready && !tx_busy) begin
                    tx_start <= 1'b1;
                    tx_byte  <= cur.bytes[idx];
                    gap      <= 1'b1;
                    if (last_byte) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rn_ctrl.sv
module rn_ctrl
    import rn_pkg::*;
#(
    parameter rn_byte_t ROUTE_OP  = 8'h04,
    parameter rn_byte_t DEAD_CODE = 8'hFF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_valid,
    input  rn_byte_t  rx_byte,
    input  rn_byte_t  route_addr,
    input  rn_byte_t  route_data,
    input  logic      seq_done,
    input  logic      seq_drop,
    output logic      load,
    output rn_burst_t burst,
    output logic      up_ready,
    output logic      exec_valid,
    output rn_byte_t  exec_op,
    output logic      err
);

    rn_state_t state, nxt;
    rn_byte_t  instr;
    logic      bad_kind;
    logic      illegal;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        burst    = '0;
        bad_kind = 1'b0;
        illegal  = 1'b0;
        case (state)
            S_IDLE: begin
                if (rx_valid) begin
                    if (rx_byte == KIND_OP) begin
                        nxt = S_GET_OP;
                    end else if (rx_byte == KIND_NEWS) begin
                        nxt = S_GET_ADDR;
                    end else if (rx_byte == DEAD_CODE) begin
                        load  = 1'b1;
                        burst = make_burst(3'd1, DEAD_CODE, '0, '0);
                        nxt   = S_DYING;
                    end else begin
                        bad_kind = 1'b1;
                    end
                end
            end
            S_GET_OP: begin
                if (rx_valid) begin
                    load  = 1'b1;
                    burst = make_burst(3'd2, KIND_OP, rx_byte, '0);
                    nxt   = S_FORWARD;
                end
            end
            S_FORWARD:  if (seq_done) nxt = S_EXEC;
            S_EXEC: begin
                if (instr == ROUTE_OP) begin
                    load  = 1'b1;
                    burst = make_burst(3'd3, KIND_NEWS, route_addr, route_data);
                    nxt   = S_ROUTE;
                end else begin
                    nxt = S_IDLE;
                end
            end
            S_ROUTE:    if (seq_done) nxt = S_IDLE;
            S_GET_ADDR: if (rx_valid) nxt = S_GET_DATA;
            S_GET_DATA: if (rx_valid) nxt = S_NOP_EXEC;
            S_NOP_EXEC: nxt = S_IDLE;
            S_DYING:    if (seq_done) nxt = S_HALT;
            S_HALT:     nxt = S_HALT;
            default: begin
                illegal = 1'b1;
                nxt     = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            instr <= OP_NOP;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_GET_OP && rx_valid) begin
                instr <= rx_byte;
            end
            err <= bad_kind | illegal | seq_drop;
        end
    end

    assign up_ready   = (state == S_IDLE) || (state == S_GET_OP) ||
                        (state == S_GET_ADDR) || (state == S_GET_DATA);
    assign exec_valid = (state == S_EXEC) || (state == S_NOP_EXEC);
    assign exec_op    = (state == S_EXEC) ? instr : OP_NOP;

endmodule

// File: rtl/ring_node.sv
module ring_node
    import rn_pkg::*;
#(
    parameter rn_byte_t ROUTE_OP  = 8'h04,
    parameter rn_byte_t DEAD_CODE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              up_ready,
    output logic              tx_start,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_busy,
    input  logic              dn_ready,
    input  logic [BYTE_W-1:0] route_addr,
    input  logic [BYTE_W-1:0] route_data,
    output logic              exec_valid,
    output logic [BYTE_W-1:0] exec_op,
    output logic              err
);

    logic      load;
    rn_burst_t burst;
    logic      seq_done;
    logic      seq_drop;

    rn_ctrl #(
        .ROUTE_OP  (ROUTE_OP),
        .DEAD_CODE (DEAD_CODE)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .route_addr (route_addr),
        .route_data (route_data),
        .seq_done   (seq_done),
        .seq_drop   (seq_drop),
        .load       (load),
        .burst      (burst),
        .up_ready   (up_ready),
        .exec_valid (exec_valid),
        .exec_op    (exec_op),
        .err        (err)
    );

    rn_tx_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .burst    (burst),
        .dn_ready (dn_ready),
        .tx_busy  (tx_busy),
        .tx_start (tx_start),
        .tx_byte  (tx_byte),
        .done     (seq_done),
        .drop     (seq_drop)
    );

endmodule

module rn_checker (
    input logic clk,
    input logic rst,
    input logic up_ready,
    input logic tx_start,
    input logic tx_busy,
    input logic dn_ready,
    input logic exec_valid,
    input logic err
);

    // R5: a start follows a cycle with downstream ready
    a_r5_start_needs_ready: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(dn_ready));

    // R5: a start follows a cycle with the transmitter free
    a_r5_start_needs_idle_tx: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(!tx_busy));

    // R5: starts never come back to back
    a_r5_start_spacing: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    // R7: execute strobe is one cycle wide
    a_r7_exec_single: assert property (@(posedge clk) disable iff (rst)
        exec_valid |=> !exec_valid);

    // R4: upstream held off while executing
    a_r4_busy_on_exec: assert property (@(posedge clk) disable iff (rst)
        exec_valid |-> !up_ready);

    // R8: upstream held off while sending
    a_r8_busy_on_send: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> !up_ready);

    // R11: error pulse is one cycle wide
    a_r11_err_single: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

endmodule

bind ring_node rn_checker i_rn_checker (
    .clk        (clk),
    .rst        (rst),
    .up_ready   (up_ready),
    .tx_start   (tx_start),
    .tx_busy    (tx_busy),
    .dn_ready   (dn_ready),
    .exec_valid (exec_valid),
    .err        (err)
);

// File: tb/test_ring_node.sv
`timescale 1ns/1ps
module test_ring_node;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       up_ready;
    logic       tx_start;
    logic [7:0] tx_byte;
    logic       tx_busy;
    logic       dn_ready = 1'b1;
    logic [7:0] route_addr = '0;
    logic [7:0] route_data = '0;
    logic       exec_valid;
    logic [7:0] exec_op;
    logic       err;

    localparam logic [7:0] ROUTE = 8'h04;
    localparam logic [7:0] DEAD  = 8'hFF;

    always #4 clk = ~clk;

    ring_node i_ring_node (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .up_ready(up_ready), .tx_start(tx_start), .tx_byte(tx_byte),
        .tx_busy(tx_busy), .dn_ready(dn_ready), .route_addr(route_addr),
        .route_data(route_data), .exec_valid(exec_valid), .exec_op(exec_op),
        .err(err)
    );

    // downstream transmitter model
    int busy_len = 0;
    int busy_cnt = 0;
    always @(posedge clk) begin
        if (rst)                busy_cnt <= 0;
        else if (tx_start)      busy_cnt <= busy_len;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
    assign tx_busy = (busy_cnt != 0);

    // observation
    logic [7:0] got[$];
    logic [7:0] exp_q[$];
    int exec_cnt = 0;
    int err_cnt = 0;
    int tx_at_exec = 0;
    logic [7:0] last_op = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_start) got.push_back(tx_byte);
            if (exec_valid) begin
                exec_cnt   = exec_cnt + 1;
                last_op    = exec_op;
                tx_at_exec = got.size();
            end
            if (err) err_cnt = err_cnt + 1;
        end
    end

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_obs();
        got.delete();
        exp_q.delete();
        exec_cnt = 0;
        err_cnt = 0;
        tx_at_exec = 0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        while (!up_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!up_ready) @(negedge clk);
        tick(8);
    endtask

    // expected stream for an instruction packet
    function automatic void build_expect(input logic [7:0] op, input logic [7:0] a,
                                         input logic [7:0] d);
        exp_q.push_back(8'h01);
        exp_q.push_back(op);
        if (op == ROUTE) begin
            exp_q.push_back(8'h02);
            exp_q.push_back(a);
            exp_q.push_back(d);
        end
    endfunction

    task automatic cmp_stream(input string req);
        chk(got.size() == exp_q.size(), req, got.size(), exp_q.size());
        if (got.size() == exp_q.size()) begin
            for (int i = 0; i < got.size(); i++)
                chk(got[i] == exp_q[i], req, got[i], exp_q[i]);
        end
    endtask

    task automatic run_instr(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d);
        clear_obs();
        route_addr = a;
        route_data = d;
        put_byte(8'h01);
        put_byte(op);
        chk(up_ready == 1'b0, "R4 ready low after instr", up_ready, 0);
        wait_idle();
        build_expect(op, a, d);
        cmp_stream(op == ROUTE ? "R8 route stream" : "R4 forward stream");
        chk(exec_cnt == 1, "R7 exec count", exec_cnt, 1);
        chk(last_op == op, "R7 exec op", last_op, op);
        chk(tx_at_exec == 2, "R4 forwarded before exec", tx_at_exec, 2);
        chk(err_cnt == 0, "R2 no error", err_cnt, 0);
        chk(up_ready == 1'b1, "R8 ready restored", up_ready, 1);
    endtask

    initial begin
        void'($urandom(32'd5150));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1
        chk(up_ready == 1'b1, "R1 up_ready", up_ready, 1);
        chk(tx_start == 1'b0, "R1 tx_start", tx_start, 0);
        chk(exec_valid == 1'b0, "R1 exec_valid", exec_valid, 0);
        chk(err == 1'b0, "R1 err", err, 0);

        // R2/R4/R7 plain instruction, R8 route
        busy_len = 3;
        run_instr(8'h33, 8'h00, 8'h00);
        run_instr(ROUTE, 8'hA5, 8'h3C);

        // R3 bad kind
        clear_obs();
        put_byte(8'h07);
        tick(4);
        chk(err_cnt == 1, "R3 err pulse", err_cnt, 1);
        chk(got.size() == 0, "R3 nothing sent", got.size(), 0);
        chk(exec_cnt == 0, "R3 no exec", exec_cnt, 0);
        chk(up_ready == 1'b1, "R3 stays ready", up_ready, 1);
        run_instr(8'h11, 8'h00, 8'h00);

        // R9 data packet consumed
        clear_obs();
        put_byte(8'h02);
        put_byte(8'h5A);
        put_byte(8'hC3);
        wait_idle();
        chk(got.size() == 0, "R9 not forwarded", got.size(), 0);
        chk(exec_cnt == 1, "R9 exec count", exec_cnt, 1);
        chk(last_op == 8'h00, "R9 nop op", last_op, 0);

        // R5 wait for downstream ready before first byte
        clear_obs();
        dn_ready = 1'b0;
        put_byte(8'h01);
        put_byte(8'h42);
        tick(10);
        chk(got.size() == 0, "R5 held while not ready", got.size(), 0);
        chk(err_cnt == 0, "R5 no error while waiting", err_cnt, 0);
        dn_ready = 1'b1;
        wait_idle();
        build_expect(8'h42, 8'h00, 8'h00);
        cmp_stream("R5 stream after wait");

        // R6 readiness lost mid-packet
        clear_obs();
        busy_len = 2;
        put_byte(8'h01);
        put_byte(8'h66);
        while (!tx_start) @(negedge clk);
        dn_ready = 1'b0;
        tick(3);
        dn_ready = 1'b1;
        wait_idle();
        exp_q.push_back(8'h01);
        exp_q.push_back(8'h01);
        exp_q.push_back(8'h66);
        cmp_stream("R6 restart stream");
        chk(err_cnt == 1, "R6 err pulse", err_cnt, 1);
        chk(exec_cnt == 1, "R6 exec once", exec_cnt, 1);

        // random mix
        for (int it = 0; it < 30; it++) begin
            logic [7:0] op;
            busy_len = $urandom_range(0, 5);
            op = ($urandom_range(0, 3) == 0) ? ROUTE : 8'($urandom_range(0, 200));
            run_instr(op, 8'($urandom), 8'($urandom));
        end

        // R10 terminator then silence
        clear_obs();
        put_byte(DEAD);
        tick(10);
        exp_q.push_back(DEAD);
        cmp_stream("R10 terminator forwarded");
        chk(up_ready == 1'b0, "R10 halted", up_ready, 0);
        rx_valid = 1'b1; rx_byte = 8'h01; tick(1);
        rx_byte = ROUTE; tick(1);
        rx_byte = 8'h02; tick(1);
        rx_valid = 1'b0;
        tick(10);
        chk(got.size() == 1, "R10 input ignored", got.size(), 1);
        chk(exec_cnt == 0, "R10 no exec", exec_cnt, 0);
        chk(up_ready == 1'b0, "R10 still halted", up_ready, 0);

        // R1 reset recovers
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        chk(up_ready == 1'b1, "R1 ready after reset", up_ready, 1);
        run_instr(8'h21, 8'h00, 8'h00);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule